// File: doc/BRIEF.md
# Pipelined Complex Radix-2 Butterfly

This unit evaluates one complex radix-2 butterfly per clock. From a complex operand A, a complex operand B and a complex twiddle W it forms the pair A + W·B and A − W·B. All parts are 16-bit signed fixed-point numbers with 15 fraction bits. The data-flow graph is mapped one operator to one hardware instance, with no sharing. W·B uses four real multipliers, one subtractor for its real part and one adder for its imaginary part. The two outputs then use two adders and two subtractors.

The schedule is fixed and as-soon-as-possible. Every multiplier takes three cycles, and every adder or subtractor takes one. The product sum completes in cycle four and the butterfly add/subtract in cycle five. Operand A passes through a four-stage delay so that it meets the complex product at the last stage. A valid strobe travels alongside the data. New operands may be presented on every cycle, with any pattern of gaps between them.

Top module: `radix2_bfly`

## Requirements
- R1: `out_valid` equals `in_valid` as it stood five rising clock edges earlier. A synchronous active-high `rst` clears every in-flight valid, so operands accepted before or during reset never raise `out_valid`.
- R2: Each real product term P(x,y) is the exact 32-bit signed product x·y, shifted right arithmetically by 15 (rounding toward minus infinity). The low 16 bits are kept.
- R3: The real part of W·B is P(b_re,w_re) − P(b_im,w_im), and the imaginary part is P(b_re,w_im) + P(b_im,w_re), both modulo 2^16.
- R4: `sum_re`/`sum_im` equal A plus W·B, component by component, modulo 2^16.
- R5: `dif_re`/`dif_im` equal A minus W·B, component by component, modulo 2^16. It follows that sum + dif equals 2·A modulo 2^16.
- R6: One butterfly is accepted on every cycle in which `in_valid` is high. Back-to-back and gapped operands each produce their own result, in input order, with no interaction between them.
- R7: Overflow wraps with no saturation. For example, P(−32768, −32768) yields the 16-bit pattern 0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operands on the inputs are a butterfly to compute |
| a_re | input | 16 | Operand A, real part (signed Q1.15) |
| a_im | input | 16 | Operand A, imaginary part |
| b_re | input | 16 | Operand B, real part |
| b_im | input | 16 | Operand B, imaginary part |
| w_re | input | 16 | Twiddle W, real part |
| w_im | input | 16 | Twiddle W, imaginary part |
| out_valid | output | 1 | Result outputs carry a finished butterfly |
| sum_re | output | 16 | A + W·B, real part |
| sum_im | output | 16 | A + W·B, imaginary part |
| dif_re | output | 16 | A − W·B, real part |
| dif_im | output | 16 | A − W·B, imaginary part |

## Verification
Directed vectors come first. A single real product with zero imaginary parts isolates the shift-and-floor rule of one multiplier. A product of −32768 by −32768 shows that overflow wraps rather than saturates. Next, a sweep walks all 4096 combinations of eight corner values across the four B and W components, with A random and a bubble every seventh cycle. This separates a swapped multiplier operand, a sign error in the cross sum and a wrong sum/difference order. A random phase with random valid gaps then checks ordering and independence under streaming. Finally, a reset applied while operands are in flight shows that those operands never emerge.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Data width of every real or imaginary component.
    localparam int DATA_W      = 16;
    // Default fraction bits removed after each real product.
    localparam int FRAC_DEF    = 15;
    // Default multiplier latency in cycles.
    localparam int MUL_LAT_DEF = 3;
    // Latency of every adder and subtractor.
    localparam int ADD_LAT     = 1;

    typedef struct packed {
        logic [DATA_W-1:0] re;
        logic [DATA_W-1:0] im;
    } cplx_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } addsub_op_e;

    // Total cycles from operand strobe to result strobe.
    function automatic int total_latency(input int mul_lat);
        return mul_lat + 2 * ADD_LAT;
    endfunction

endpackage

// File: rtl/bfly_delay.sv
module bfly_delay #(
    parameter int W   = 1,
    parameter int N   = 1,
    parameter bit CLR = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (N == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stg [N];

            always_ff @(posedge clk) begin
                if (CLR && rst) begin
                    for (int i = 0; i < N; i++) begin
                        stg[i] <= '0;
                    end
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < N; i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end

            assign q = stg[N-1];
        end
    endgenerate

endmodule

// File: rtl/bfly_mul.sv
module bfly_mul #(
    parameter int DW   = 16,
    parameter int FRAC = 15,
    parameter int LAT  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] p
);

    localparam int FW = 2 * DW;

    logic signed [FW-1:0] full;
    logic signed [FW-1:0] shifted;
    logic [DW-1:0]        pipe [LAT];
    logic                 prod_unused;

    // Exact signed product, floor-shifted, low DW bits kept (wrapping).
    assign full        = $signed(a) * $signed(b);
    assign shifted     = full >>> FRAC;
    assign prod_unused = ^shifted[FW-1:DW];

    always_ff @(posedge clk) begin
        pipe[0] <= shifted[DW-1:0];
        for (int i = 1; i < LAT; i++) begin
            pipe[i] <= pipe[i-1];
        end
    end

    assign p = pipe[LAT-1];

    // R2: a zero operand LAT cycles ago gives a zero product term now.
    p_mul_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (($past(a, LAT) == '0) || ($past(b, LAT) == '0)) |-> (p == '0));

endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub
    import bfly_pkg::*;
#(
    parameter int         W  = DATA_W,
    parameter addsub_op_e OP = OP_ADD
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    logic [W-1:0] nxt;

    generate
        if (OP == OP_SUB) begin : g_sub
            assign nxt = a - b;

            // R3: equal operands one cycle ago leave a zero difference.
            p_sub_zero_r3: assert property (@(posedge clk) disable iff (rst)
                ($past(a) == $past(b)) |-> (y == '0));
        end else begin : g_add
            assign nxt = a + b;

            // R3: adding zero passes the other operand through one cycle later.
            p_add_ident_r3: assert property (@(posedge clk) disable iff (rst)
                ($past(b) == '0) |-> (y == $past(a)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        y <= nxt;
    end

endmodule

// File: rtl/radix2_bfly.sv
module radix2_bfly
    import bfly_pkg::*;
#(
    parameter int FRAC    = FRAC_DEF,
    parameter int MUL_LAT = MUL_LAT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] a_re,
    input  logic [DATA_W-1:0] a_im,
    input  logic [DATA_W-1:0] b_re,
    input  logic [DATA_W-1:0] b_im,
    input  logic [DATA_W-1:0] w_re,
    input  logic [DATA_W-1:0] w_im,
    output logic              out_valid,
    output logic [DATA_W-1:0] sum_re,
    output logic [DATA_W-1:0] sum_im,
    output logic [DATA_W-1:0] dif_re,
    output logic [DATA_W-1:0] dif_im
);

    localparam int DW        = DATA_W;
    localparam int N_MUL     = 4;
    localparam int A_DLY     = MUL_LAT + ADD_LAT;
    localparam int LAT_TOTAL = total_latency(MUL_LAT);

    cplx_t op_a, op_b, op_w;
    cplx_t a_al;      // A aligned with the complex product
    cplx_t wb;        // W*B
    cplx_t sum_c, dif_c;

    assign op_a = '{re: a_re, im: a_im};
    assign op_b = '{re: b_re, im: b_im};
    assign op_w = '{re: w_re, im: w_im};

    // Multiplier operand routing: 0 br*wr, 1 bi*wi, 2 br*wi, 3 bi*wr.
    logic [DW-1:0] m_x [N_MUL];
    logic [DW-1:0] m_y [N_MUL];
    logic [DW-1:0] m_p [N_MUL];

    assign m_x[0] = op_b.re;  assign m_y[0] = op_w.re;
    assign m_x[1] = op_b.im;  assign m_y[1] = op_w.im;
    assign m_x[2] = op_b.re;  assign m_y[2] = op_w.im;
    assign m_x[3] = op_b.im;  assign m_y[3] = op_w.re;

    generate
        for (genvar gi = 0; gi < N_MUL; gi++) begin : g_mul
            bfly_mul #(
                .DW  (DW),
                .FRAC(FRAC),
                .LAT (MUL_LAT)
            ) u_mul (
                .clk(clk),
                .rst(rst),
                .a  (m_x[gi]),
                .b  (m_y[gi]),
                .p  (m_p[gi])
            );
        end
    endgenerate

    // Complex product level: one subtractor, one adder.
    bfly_addsub #(.W(DW), .OP(OP_SUB)) u_wb_re (
        .clk(clk), .rst(rst), .a(m_p[0]), .b(m_p[1]), .y(wb.re)
    );
    bfly_addsub #(.W(DW), .OP(OP_ADD)) u_wb_im (
        .clk(clk), .rst(rst), .a(m_p[2]), .b(m_p[3]), .y(wb.im)
    );

    // Balance A against multiply plus product-sum.
    bfly_delay #(.W(2 * DW), .N(A_DLY), .CLR(1'b0)) u_a_dly (
        .clk(clk), .rst(rst), .d(op_a), .q(a_al)
    );

    // Butterfly level: two adders, two subtractors.
    bfly_addsub #(.W(DW), .OP(OP_ADD)) u_sum_re (
        .clk(clk), .rst(rst), .a(a_al.re), .b(wb.re), .y(sum_c.re)
    );
    bfly_addsub #(.W(DW), .OP(OP_ADD)) u_sum_im (
        .clk(clk), .rst(rst), .a(a_al.im), .b(wb.im), .y(sum_c.im)
    );
    bfly_addsub #(.W(DW), .OP(OP_SUB)) u_dif_re (
        .clk(clk), .rst(rst), .a(a_al.re), .b(wb.re), .y(dif_c.re)
    );
    bfly_addsub #(.W(DW), .OP(OP_SUB)) u_dif_im (
        .clk(clk), .rst(rst), .a(a_al.im), .b(wb.im), .y(dif_c.im)
    );

    // Valid strobe follows the full schedule and is cleared by reset.
    bfly_delay #(.W(1), .N(LAT_TOTAL), .CLR(1'b1)) u_vld_dly (
        .clk(clk), .rst(rst), .d(in_valid), .q(out_valid)
    );

    assign sum_re = sum_c.re;
    assign sum_im = sum_c.im;
    assign dif_re = dif_c.re;
    assign dif_im = dif_c.im;

    logic [DW-1:0] chk_re, chk_im;
    assign chk_re = sum_c.re + dif_c.re;
    assign chk_im = sum_c.im + dif_c.im;

    // R1: a result strobe always traces back to an operand strobe.
    p_vld_lat_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, LAT_TOTAL));

    // R5: sum and difference together recover twice the aligned A.
    p_sym_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((chk_re == DW'($past(a_re, LAT_TOTAL) << 1)) &&
                       (chk_im == DW'($past(a_im, LAT_TOTAL) << 1))));

endmodule

// File: tb/radix2_bfly_test.sv
`timescale 1ns/1ps
module radix2_bfly_test;

    localparam int NMAX = 8192;
    localparam int LAT  = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0, w_re = '0, w_im = '0;
    logic        out_valid;
    logic [15:0] sum_re, sum_im, dif_re, dif_im;

    always #10 clk = ~clk;

    radix2_bfly uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .w_re(w_re), .w_im(w_im),
        .out_valid(out_valid),
        .sum_re(sum_re), .sum_im(sum_im), .dif_re(dif_re), .dif_im(dif_im)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    done  = 1'b0;

    logic        exp_v  [NMAX];
    logic [15:0] exp_sr [NMAX];
    logic [15:0] exp_si [NMAX];
    logic [15:0] exp_dr [NMAX];
    logic [15:0] exp_di [NMAX];
    string       exp_tag[NMAX];

    // R2: floor-shifted signed product, low 16 bits.
    function automatic logic [15:0] pterm(logic [15:0] x, logic [15:0] y);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        p = p >>> 15;
        return p[15:0];
    endfunction

    function automatic logic [15:0] corner(int k);
        case (k)
            0: return 16'h8000;
            1: return 16'h8001;
            2: return 16'hFFFF;
            3: return 16'h0000;
            4: return 16'h0001;
            5: return 16'h4000;
            6: return 16'h7FFF;
            default: return 16'h3039;
        endcase
    endfunction

    task automatic chk16(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    task automatic check_out();
        logic ev;
        int   idx;
        idx = cyc - LAT;
        ev  = (idx >= 0) ? exp_v[idx] : 1'b0;
        n_vec++;
        if (out_valid !== ev) begin
            n_bad++;
            $display("FAIL R1 out_valid at cycle %0d: actual %b expected %b", cyc, out_valid, ev);
        end
        if (ev === 1'b1) begin
            chk16({"R4 ", exp_tag[idx]}, "sum_re", sum_re, exp_sr[idx]);
            chk16({"R4 ", exp_tag[idx]}, "sum_im", sum_im, exp_si[idx]);
            chk16({"R5 ", exp_tag[idx]}, "dif_re", dif_re, exp_dr[idx]);
            chk16({"R5 ", exp_tag[idx]}, "dif_im", dif_im, exp_di[idx]);
        end
    endtask

    task automatic step(bit v, logic [15:0] ar, logic [15:0] ai, logic [15:0] br,
                        logic [15:0] bi, logic [15:0] wr, logic [15:0] wi, string tag);
        logic [15:0] xr, xi;
        @(negedge clk);
        check_out();
        rst      = 1'b0;
        in_valid = v;
        a_re = ar; a_im = ai; b_re = br; b_im = bi; w_re = wr; w_im = wi;
        // R3: complex product from the four product terms.
        xr = pterm(br, wr) - pterm(bi, wi);
        xi = pterm(br, wi) + pterm(bi, wr);
        exp_v[cyc]   = v;
        exp_sr[cyc]  = ar + xr;
        exp_si[cyc]  = ai + xi;
        exp_dr[cyc]  = ar - xr;
        exp_di[cyc]  = ai - xi;
        exp_tag[cyc] = tag;
        cyc++;
    endtask

    // Reset while operands are in flight: R1 says none of them emerge.
    task automatic rst_step();
        @(negedge clk);
        check_out();
        rst      = 1'b1;
        in_valid = 1'b1;
        exp_v[cyc] = 1'b0;
        for (int k = 1; k < LAT; k++) begin
            if (cyc - k >= 0) exp_v[cyc - k] = 1'b0;
        end
        cyc++;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        // R1: reset state.
        n_vec++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset out_valid: actual %b expected 0", out_valid);
        end

        // R7: wrap of the most negative square.
        step(1, 16'h0000, 16'h0000, 16'h8000, 16'h0000, 16'h8000, 16'h0000, "R7");
        step(1, 16'h7FFF, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, "R7");
        // R2: single real product, exact and floored.
        step(1, 16'h0100, 16'h0000, 16'h4000, 16'h0000, 16'h4000, 16'h0000, "R2");
        step(1, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h0001, 16'h0000, "R2");
        step(1, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h7FFF, "R2");
        step(0, 16'h1234, 16'h5678, 16'h1111, 16'h2222, 16'h3333, 16'h4444, "R6");

        // R3: corner sweep over B and W, A random, bubble every seventh cycle.
        for (int i = 0; i < 4096; i++) begin
            step((i % 7) != 6, 16'($urandom), 16'($urandom),
                 corner(i & 7), corner((i >> 3) & 7),
                 corner((i >> 6) & 7), corner((i >> 9) & 7), "R3");
        end

        // R6: random operands with random valid gaps.
        for (int i = 0; i < 1500; i++) begin
            step(($urandom % 10) < 7, 16'($urandom), 16'($urandom), 16'($urandom),
                 16'($urandom), 16'($urandom), 16'($urandom), "R6");
        end

        // R1: reset with operands in flight.
        for (int i = 0; i < 3; i++) begin
            step(1, 16'($urandom), 16'($urandom), 16'($urandom),
                 16'($urandom), 16'($urandom), 16'($urandom), "R1");
        end
        rst_step();
        for (int i = 0; i < 3; i++) begin
            step(1, 16'($urandom), 16'($urandom), 16'($urandom),
                 16'($urandom), 16'($urandom), 16'($urandom), "R1");
        end
        for (int i = 0; i < 8; i++) begin
            step(0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, "R1");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule